// File: doc/BRIEF.md
# Symbol-Wide Pseudorandom Pattern Generator

This block produces a 12-bit pseudorandom test pattern from four cascaded 3-bit registers, each holding one element of the eight-element field built on x^3 + x + 1. On each enabled step, the symbol in the top register is the feedback. It is multiplied by a fixed field constant chosen for each register and XORed into every register as the symbols move up one place. Because whole symbols move per step rather than single bits, consecutive patterns are less alike than those of a plain bit-serial shift register. The default constants form a primitive degree-4 polynomial over the field, so any non-zero start cycles through all 4095 non-zero patterns.

A synchronous reset restarts the sequence from a parameter seed, which is all ones by default. A load port replaces the state with a caller-supplied seed. A zero seed would lock the generator in the all-zero state, so such a load is refused and an error flag reports it.

Top module: `glfsr_gf8`

## Requirements
- R1: When `rst` is high at a clock edge, `state` becomes `INIT_SEED` (default 12'hFFF) and `seed_err` becomes 0.
- R2: When `load` is high at a clock edge (without `rst`) and `seed` is non-zero, `state` becomes `seed` and `seed_err` becomes 0.
- R3: When `load` is high (without `rst`) and `seed` is zero, `state` keeps its value and `seed_err` becomes 1.
- R4: Register k is `state[3k+2:3k]`, and its bit 0 is the x^0 coefficient. When `step` is high and neither `rst` nor `load` is high, the feedback is fb = `state[11:9]`. Register 0 takes fb·C0, and register k>0 takes old register k-1 XOR fb·Ck. Products are reduced modulo x^3+x+1. The defaults are C0=7, C1=0, C2=5, C3=2.
- R5: From state 12'hFFF, one step gives 12'h47B and a second step gives 12'hB9D.
- R6: With `rst`, `load` and `step` all low, `state` and `seed_err` hold.
- R7: With the default constants and a non-zero start, `state` never becomes zero under stepping and first returns to its start after exactly 4095 steps.
- R8: `rst` takes priority over `load`, and `load` takes priority over `step`. A cycle with `load` and `step` both high performs only the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to the parameter seed |
| load | input | 1 | Load `seed` into the state |
| seed | input | 12 | Seed value for a load |
| step | input | 1 | Advance one pattern |
| state | output | 12 | Current pattern |
| seed_err | output | 1 | Last load was refused because the seed was zero |

## Verification
The assertions assume that `rst` is high at the first clock edge, so every register has a defined value before any property is checked. The non-zero invariant depends on this, because reset and refused loads are the only routes into the state. The stimulus holds reset over the first edges. It then mixes random loads, some with zero seeds, with random step and idle cycles and occasional resets. A directed full-period run checks the sequence length.

// File: rtl/glfsr_gf8.sv
module glfsr_gf8 #(
  parameter logic [2:0]  COEF0     = 3'd7,
  parameter logic [2:0]  COEF1     = 3'd0,
  parameter logic [2:0]  COEF2     = 3'd5,
  parameter logic [2:0]  COEF3     = 3'd2,
  parameter logic [11:0] INIT_SEED = 12'hFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [11:0] seed,
  input  logic        step,
  output logic [11:0] state,
  output logic        seed_err
);
  localparam int SYM    = 3;
  localparam int STAGES = 4;
  localparam int W      = SYM * STAGES;
  localparam logic [W-1:0] COEFS = {COEF3, COEF2, COEF1, COEF0};

  function automatic logic [SYM-1:0] gf_mul(input logic [SYM-1:0] a, input logic [SYM-1:0] b);
    logic [SYM-1:0] acc, t;
    acc = '0;
    t   = a;
    for (int i = 0; i < SYM; i++) begin
      if (b[i]) acc = acc ^ t;
      t = {t[SYM-2:0], 1'b0} ^ (t[SYM-1] ? 3'b011 : 3'b000);
    end
    return acc;
  endfunction

  logic [SYM-1:0] fb;
  logic [W-1:0]   nxt;
  assign fb = state[W-1 -: SYM];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign nxt[SYM-1:0] = gf_mul(fb, COEFS[SYM-1:0]);
    end else begin : g_rest
      assign nxt[k*SYM +: SYM] = state[(k-1)*SYM +: SYM] ^ gf_mul(fb, COEFS[k*SYM +: SYM]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= INIT_SEED;
      seed_err <= 1'b0;
    end else if (load) begin
      if (seed != '0) begin
        state    <= seed;
        seed_err <= 1'b0;
      end else begin
        seed_err <= 1'b1;
      end
    end else if (step) begin
      state <= nxt;
    end
  end

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  assert_reset_seed_R1: assert property (@(posedge clk)
    primed && $past(rst) |-> state == INIT_SEED && !seed_err);
  assert_load_ok_R2: assert property (@(posedge clk) disable iff (rst)
    load && seed != '0 |=> state == $past(seed) && !seed_err);
  assert_zero_refused_R3: assert property (@(posedge clk) disable iff (rst)
    load && seed == '0 |=> $stable(state) && seed_err);
  assert_zero_fb_shift_R4: assert property (@(posedge clk) disable iff (rst)
    step && !load && state[W-1 -: SYM] == '0 |=> state == {$past(state[W-SYM-1:0]), {SYM{1'b0}}});
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load && !step |=> $stable(state) && $stable(seed_err));
  assert_never_zero_R7: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: tb/glfsr_gf8_bench.sv
module glfsr_gf8_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, load = 1'b0, step = 1'b0;
  logic [11:0] seed = '0;
  logic [11:0] state;
  logic seed_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  glfsr_gf8 u_glfsr_gf8 (.clk(clk), .rst(rst), .load(load), .seed(seed), .step(step),
                         .state(state), .seed_err(seed_err));

  function automatic logic [2:0] fmul(input logic [2:0] a, input logic [2:0] b);
    logic [4:0] p = '0;
    for (int i = 0; i < 3; i++) if (b[i]) p = p ^ (5'(a) << i);
    if (p[4]) p = p ^ 5'b10110;
    if (p[3]) p = p ^ 5'b01011;
    return p[2:0];
  endfunction

  function automatic logic [11:0] model_next(input logic [11:0] s);
    logic [2:0] f = s[11:9];
    logic [2:0] c [4] = '{3'd7, 3'd0, 3'd5, 3'd2};
    logic [11:0] n;
    n[2:0]  = fmul(f, c[0]);
    n[5:3]  = s[2:0] ^ fmul(f, c[1]);
    n[8:6]  = s[5:3] ^ fmul(f, c[2]);
    n[11:9] = s[8:6] ^ fmul(f, c[3]);
    return n;
  endfunction

  task automatic check(input string tag, input logic [11:0] es, input logic ee);
    checks++;
    if (state !== es || seed_err !== ee) begin
      errors++;
      $display("FAIL %s state=%h err=%b expected state=%h err=%b", tag, state, seed_err, es, ee);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] ms;
    logic me;
    string tag;
    void'($urandom(32'd2024));
    tick(); tick();
    check("R1 reset", 12'hFFF, 1'b0);
    rst = 0; step = 1; tick();
    check("R5 first step", 12'h47B, 1'b0);
    tick();
    check("R5 second step", 12'hB9D, 1'b0);
    step = 0; tick(); tick();
    check("R6 idle hold", 12'hB9D, 1'b0);
    load = 1; seed = 12'h000; tick();
    check("R3 zero seed refused", 12'hB9D, 1'b1);
    step = 1; tick();
    check("R3 zero seed with step", 12'hB9D, 1'b1);
    seed = 12'h801; tick();
    check("R8 load over step, R2", 12'h801, 1'b0);
    load = 0; tick();
    check("R4 top-bit seed step", model_next(12'h801), 1'b0);
    rst = 1; load = 1; seed = 12'h123; tick();
    check("R8 reset over load", 12'hFFF, 1'b0);
    rst = 0; load = 0; step = 0;

    ms = state; me = seed_err;
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 100;
      rst  = (r < 2);
      load = (r >= 2 && r < 14);
      seed = (r % 3 == 0) ? 12'h000 : 12'($urandom);
      step = ($urandom % 4) != 0;
      if (rst) begin ms = 12'hFFF; me = 0; tag = "R1 random reset"; end
      else if (load) begin
        if (seed != 0) begin ms = seed; me = 0; tag = "R2 random load"; end
        else begin me = 1; tag = "R3 random zero load"; end
      end else if (step) begin ms = model_next(ms); tag = "R4 random step"; end
      else tag = "R6 random idle";
      tick();
      check(tag, ms, me);
    end

    rst = 1; load = 0; step = 0; tick();
    rst = 0; step = 1;
    begin
      int first = 0;
      bit zero_seen = 0;
      for (int n = 1; n <= 4095; n++) begin
        tick();
        if (state == 12'h000) zero_seen = 1;
        if (state == 12'hFFF && first == 0) first = n;
      end
      checks++;
      if (zero_seen) begin errors++; $display("FAIL R7 zero state reached actual=1 expected=0"); end
      checks++;
      if (first != 4095) begin errors++; $display("FAIL R7 period actual=%0d expected=4095", first); end
    end
    step = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule